// File: doc/BRIEF.md
# Dual-Timebase Capture/Compare Array

This block provides two free-running 16-bit up-counters and an array of eight capture/compare channels. Each counter advances by one on every cycle in which the shared timer clock enable is high. When it steps past 0xFFFF, it reloads from its own reload register and raises a one-cycle overflow interrupt. Each channel is bound to one of the two counters by its control word. It either captures the counter value on a selected edge of its input pin, or compares its register against the counter and reacts with an interrupt, a pin action, or both.

A channel compare "match" is the cycle in which the assigned counter steps onto the channel's register value. A counter that is held, or that is loaded by a write, never produces a match. Four compare behaviours are provided: interrupt on every match, toggle the pin on every match, interrupt only on the first match of a counter period, and set the pin on the first match with a clear on counter overflow. A global paired mode lets channel k and channel k+4 share pin k, and a match in either of them toggles that pin.

Configuration goes through a single write port. A read port returns the channel registers and the counter values. Pin multiplexing to the outside world is handled elsewhere.

Top module: `ccu_dual_timebase`

## Requirements
- R1: After reset, both counters, both reload registers and all channel registers read 0; all pins, channel interrupts and counter interrupts are 0; every channel is in mode 000 (off) on counter 0; paired mode is off.
- R2: A counter adds 1 on each cycle with `tick_en` high and holds otherwise. A step taken at 0xFFFF loads the reload value instead and pulses that counter's bit of `tmr_irq` during the following cycle.
- R3: Capture modes are 001 (rising), 010 (falling) and 011 (both edges). The pin is synchronised by two flops. On the third clock edge after the pin changes, the assigned counter value is copied into the channel register and `ch_irq` pulses for one cycle. Edges that are not selected do nothing.
- R4: Mode 100 pulses the channel interrupt on every match, including several in one counter period when the register is rewritten.
- R5: Mode 101 toggles the channel pin and pulses the channel interrupt on every match.
- R6: Mode 110 pulses the interrupt only on the first match after the assigned counter's last overflow (or after a control write); later matches in the same period are ignored.
- R7: Mode 111 sets the pin and pulses the interrupt on the first match in a period, and clears the pin on the assigned counter's overflow. Pins change only on cycles following a `tick_en` step.
- R8: Control bit 3 selects counter 1 (1) or counter 0 (0) as the channel's time base; bits 2:0 hold the mode.
- R9: With paired mode on (address 20, bit 0), pin k for k<4 toggles once when channel k, channel k+4 or both match in any compare mode; pins 4..7 hold; interrupts follow each channel's own mode.
- R10: Write addresses: 0..7 channel registers, 8..15 channel control, 16/17 counter 0/1, 18/19 reload 0/1, 20 global. Read addresses 0..7 return channel registers, 8/9 return counters 0/1.
- R11: Mode 000 produces no interrupt, no capture and no pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter step enable |
| pin_in | input | 8 | Channel capture inputs |
| pin_out | output | 8 | Channel compare outputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, combinational |
| ch_irq | output | 8 | Per-channel interrupt pulses |
| tmr_irq | output | 2 | Per-counter overflow pulses |

## Verification
The assertions assume that `tick_en` is low while reset is asserted. This matters because several properties look one cycle back at the step enable right after reset is released. They also assume that `tick_en` is the only thing that advances a counter apart from a direct write. The stimulus therefore keeps `tick_en` low during reset and during every configuration write. It raises `tick_en` for exactly one clock per step, so that each match, overflow and pin change can be tied to a known step.

// File: rtl/ccu_dual_timebase_pkg.sv
package ccu_dual_timebase_pkg;

    typedef enum logic [2:0] {
        MODE_OFF        = 3'b000,
        MODE_CAP_RISE   = 3'b001,
        MODE_CAP_FALL   = 3'b010,
        MODE_CAP_BOTH   = 3'b011,
        MODE_CMP_EVERY  = 3'b100,
        MODE_CMP_TOGGLE = 3'b101,
        MODE_CMP_ONCE   = 3'b110,
        MODE_CMP_SETCLR = 3'b111
    } cc_mode_e;

    typedef struct packed {
        logic     tsel;
        cc_mode_e mode;
    } cc_cfg_t;

endpackage

// File: rtl/ccu_timer.sv
module ccu_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          wr_cnt_i,
    input  logic          wr_rel_i,
    input  logic [TW-1:0] wr_data_i,
    output logic [TW-1:0] cnt_o,
    output logic [TW-1:0] nxt_o,
    output logic          adv_o,
    output logic          ovf_o,
    output logic          irq_o
);
    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic [TW-1:0] rel;
        logic          irq;
    } tmr_state_t;

    tmr_state_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.irq = 1'b0;
        adv_o     = step_i && !wr_cnt_i;
        ovf_o     = adv_o && (tmr_q.cnt == CNT_MAX);
        if (wr_cnt_i) begin
            tmr_d.cnt = wr_data_i;
        end else if (step_i) begin
            tmr_d.cnt = ovf_o ? tmr_q.rel : tmr_q.cnt + 1'b1;
        end
        if (wr_rel_i) begin
            tmr_d.rel = wr_data_i;
        end
        tmr_d.irq = ovf_o;
        nxt_o     = tmr_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign cnt_o = tmr_q.cnt;
    assign irq_o = tmr_q.irq;

endmodule

// File: rtl/ccu_edge_sync.sv
module ccu_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_state_t;

    sync_state_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = pin_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rise_o = sync_q.s2 && !sync_q.s3;
    assign fall_o = !sync_q.s2 && sync_q.s3;

endmodule

// File: rtl/ccu_channel.sv
module ccu_channel
    import ccu_dual_timebase_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_val_i,
    input  logic          wr_cfg_i,
    input  logic [TW-1:0] wr_data_i,
    input  logic [TW-1:0] t_cnt_i,
    input  logic [TW-1:0] t_nxt_i,
    input  logic          t_adv_i,
    input  logic          t_ovf_i,
    input  logic          rise_i,
    input  logic          fall_i,
    output logic [TW-1:0] val_o,
    output cc_cfg_t       cfg_o,
    output logic          irq_o,
    output logic          hit_o,
    output logic          tgl_o,
    output logic          set_o,
    output logic          clr_o
);
    typedef struct packed {
        logic [TW-1:0] val;
        cc_cfg_t       cfg;
        logic          armed;
        logic          irq;
    } ch_state_t;

    ch_state_t ch_d, ch_q;

    logic is_cmp, once_kind, armed_eff, cap_evt, fire;

    always_comb begin
        ch_d      = ch_q;
        is_cmp    = ch_q.cfg.mode[2];
        once_kind = (ch_q.cfg.mode == MODE_CMP_ONCE) || (ch_q.cfg.mode == MODE_CMP_SETCLR);
        hit_o     = is_cmp && t_adv_i && (t_nxt_i == ch_q.val);
        armed_eff = ch_q.armed || t_ovf_i;
        cap_evt   = ((ch_q.cfg.mode == MODE_CAP_RISE || ch_q.cfg.mode == MODE_CAP_BOTH) && rise_i)
                 || ((ch_q.cfg.mode == MODE_CAP_FALL || ch_q.cfg.mode == MODE_CAP_BOTH) && fall_i);

        unique case (ch_q.cfg.mode)
            MODE_CMP_EVERY, MODE_CMP_TOGGLE: fire = hit_o;
            MODE_CMP_ONCE, MODE_CMP_SETCLR:  fire = hit_o && armed_eff;
            MODE_CAP_RISE, MODE_CAP_FALL,
            MODE_CAP_BOTH:                   fire = cap_evt;
            default:                         fire = 1'b0;
        endcase

        ch_d.armed = armed_eff && !(fire && once_kind);
        if (cap_evt) begin
            ch_d.val = t_cnt_i;
        end
        if (wr_val_i) begin
            ch_d.val = wr_data_i;
        end
        if (wr_cfg_i) begin
            ch_d.cfg.mode = cc_mode_e'(wr_data_i[2:0]);
            ch_d.cfg.tsel = wr_data_i[3];
            ch_d.armed    = 1'b1;
        end
        ch_d.irq = fire;

        tgl_o = (ch_q.cfg.mode == MODE_CMP_TOGGLE) && hit_o;
        set_o = (ch_q.cfg.mode == MODE_CMP_SETCLR) && fire;
        clr_o = (ch_q.cfg.mode == MODE_CMP_SETCLR) && t_ovf_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q       <= '0;
            ch_q.armed <= 1'b1;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign val_o = ch_q.val;
    assign cfg_o = ch_q.cfg;
    assign irq_o = ch_q.irq;

endmodule

// File: rtl/ccu_dual_timebase.sv
module ccu_dual_timebase
    import ccu_dual_timebase_pkg::*;
#(
    parameter  int NCH = 8,
    parameter  int TW  = 16,
    localparam int AW  = $clog2(2 * NCH + 5),
    localparam int RW  = $clog2(NCH + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_en,
    input  logic [NCH-1:0] pin_in,
    output logic [NCH-1:0] pin_out,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [TW-1:0]  wr_data,
    input  logic [RW-1:0]  rd_addr,
    output logic [TW-1:0]  rd_data,
    output logic [NCH-1:0] ch_irq,
    output logic [1:0]     tmr_irq
);
    localparam int HALF  = NCH / 2;
    localparam int CW    = $clog2(NCH);
    localparam int A_CTL = NCH;
    localparam int A_TMR = 2 * NCH;
    localparam int A_REL = 2 * NCH + 2;
    localparam int A_GLB = 2 * NCH + 4;

    logic [TW-1:0] tcnt [2];
    logic [TW-1:0] tnxt [2];
    logic [1:0]    tadv, tovf;

    for (genvar t = 0; t < 2; t++) begin : g_tmr
        ccu_timer #(.TW(TW)) tmr_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_i    (tick_en),
            .wr_cnt_i  (wr_en && wr_addr == AW'(A_TMR + t)),
            .wr_rel_i  (wr_en && wr_addr == AW'(A_REL + t)),
            .wr_data_i (wr_data),
            .cnt_o     (tcnt[t]),
            .nxt_o     (tnxt[t]),
            .adv_o     (tadv[t]),
            .ovf_o     (tovf[t]),
            .irq_o     (tmr_irq[t])
        );
    end

    logic [TW-1:0]  val_arr [NCH];
    cc_cfg_t        cfg_arr [NCH];
    logic [NCH-1:0] hit, tgl, set, clr, cmp_mask;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic rise, fall, sel;
        assign sel         = cfg_arr[i].tsel;
        assign cmp_mask[i] = cfg_arr[i].mode[2];

        ccu_edge_sync sync_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_in[i]),
            .rise_o (rise),
            .fall_o (fall)
        );

        ccu_channel #(.TW(TW)) ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_val_i  (wr_en && wr_addr == AW'(i)),
            .wr_cfg_i  (wr_en && wr_addr == AW'(A_CTL + i)),
            .wr_data_i (wr_data),
            .t_cnt_i   (tcnt[sel]),
            .t_nxt_i   (tnxt[sel]),
            .t_adv_i   (tadv[sel]),
            .t_ovf_i   (tovf[sel]),
            .rise_i    (rise),
            .fall_i    (fall),
            .val_o     (val_arr[i]),
            .cfg_o     (cfg_arr[i]),
            .irq_o     (ch_irq[i]),
            .hit_o     (hit[i]),
            .tgl_o     (tgl[i]),
            .set_o     (set[i]),
            .clr_o     (clr[i])
        );
    end

    typedef struct packed {
        logic           dbl;
        logic [NCH-1:0] pins;
    } top_state_t;

    top_state_t top_d, top_q;

    always_comb begin
        top_d = top_q;
        if (wr_en && wr_addr == AW'(A_GLB)) begin
            top_d.dbl = wr_data[0];
        end
        for (int i = 0; i < NCH; i++) begin
            if (top_q.dbl) begin
                if (i < HALF && (hit[i] || hit[(i + HALF) % NCH])) begin
                    top_d.pins[i] = ~top_q.pins[i];
                end
            end else begin
                if (tgl[i]) top_d.pins[i] = ~top_q.pins[i];
                if (clr[i]) top_d.pins[i] = 1'b0;
                if (set[i]) top_d.pins[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign pin_out = top_q.pins;

    always_comb begin
        if (rd_addr < RW'(NCH)) begin
            rd_data = val_arr[rd_addr[CW-1:0]];
        end else if (rd_addr == RW'(NCH)) begin
            rd_data = tcnt[0];
        end else if (rd_addr == RW'(NCH + 1)) begin
            rd_data = tcnt[1];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/ccu_dual_timebase_chk.sv
module ccu_dual_timebase_chk #(
    parameter int NCH = 8,
    parameter int TW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_en,
    input logic           wr_en,
    input logic [NCH-1:0] pin_out,
    input logic [NCH-1:0] ch_irq,
    input logic [1:0]     tmr_irq,
    input logic [TW-1:0]  tcnt0,
    input logic [TW-1:0]  tcnt1,
    input logic           dbl,
    input logic [NCH-1:0] cmp_mask
);
    localparam int HALF = NCH / 2;
    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    // R2: an overflow pulse follows a step taken at the top count
    a_r2_ovf_from_max0: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq[0] |-> ($past(tick_en) && $past(tcnt0) == CNT_MAX));
    a_r2_ovf_from_max1: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq[1] |-> ($past(tick_en) && $past(tcnt1) == CNT_MAX));

    // R2: without a step or a write the counters hold
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick_en) && !$past(wr_en)) |-> (tcnt0 == $past(tcnt0) && tcnt1 == $past(tcnt1)));

    // R7: pins move only after a counter step
    a_r7_pins_need_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_en) |-> (pin_out == $past(pin_out)));

    // R9: in paired mode the upper pins hold
    a_r9_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dbl) |-> (pin_out[NCH-1:HALF] == $past(pin_out[NCH-1:HALF])));

    // R4: a compare-mode interrupt needs a counter step
    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        a_r4_cmp_irq_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(cmp_mask[i]) && !$past(tick_en)) |-> !ch_irq[i]);
    end

endmodule

bind ccu_dual_timebase ccu_dual_timebase_chk #(.NCH(NCH), .TW(TW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wr_en    (wr_en),
    .pin_out  (pin_out),
    .ch_irq   (ch_irq),
    .tmr_irq  (tmr_irq),
    .tcnt0    (tcnt[0]),
    .tcnt1    (tcnt[1]),
    .dbl      (top_q.dbl),
    .cmp_mask (cmp_mask)
);

// File: tb/ccu_dual_timebase_tb.sv
module ccu_dual_timebase_tb_top;

    localparam int A_CTL = 8;
    localparam int A_TMR = 16;
    localparam int A_REL = 18;
    localparam int A_GLB = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  ch_irq;
    logic [1:0]  tmr_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ccu_dual_timebase dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ch_irq  (ch_irq),
        .tmr_irq (tmr_irq)
    );

    typedef struct packed {
        logic [2:0] ch;
        logic [2:0] mode;
        logic       tsel;
        logic [4:0] steps;
        logic [4:0] wstep;
        logic [3:0] exp_irq;
        logic       exp_pin;
        logic [3:0] exp_tirq;
    } vec_t;

    // counter from 0xFFFA, reload 0xFFFC, register 0xFFFB, rewritten to 0xFFFD after wstep
    localparam vec_t VECS [10] = '{
        '{3'd2, 3'b100, 1'b0, 5'd12, 5'd1, 4'd4, 1'b0, 4'd2},
        '{3'd3, 3'b101, 1'b0, 5'd12, 5'd1, 4'd4, 1'b0, 4'd2},
        '{3'd4, 3'b101, 1'b0, 5'd7,  5'd1, 4'd3, 1'b1, 4'd1},
        '{3'd5, 3'b110, 1'b0, 5'd12, 5'd1, 4'd3, 1'b0, 4'd2},
        '{3'd6, 3'b111, 1'b0, 5'd12, 5'd1, 4'd3, 1'b1, 4'd2},
        '{3'd7, 3'b111, 1'b0, 5'd10, 5'd1, 4'd2, 1'b0, 4'd2},
        '{3'd1, 3'b111, 1'b1, 5'd12, 5'd1, 4'd3, 1'b1, 4'd2},
        '{3'd0, 3'b000, 1'b0, 5'd12, 5'd1, 4'd0, 1'b0, 4'd2},
        '{3'd2, 3'b100, 1'b0, 5'd12, 5'd0, 4'd1, 1'b0, 4'd2},
        '{3'd3, 3'b110, 1'b1, 5'd12, 5'd0, 4'd1, 1'b0, 4'd2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_en = 1'b0;
        pin_in = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1'b1;
        wr_addr = 5'(addr);
        wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    int irq_cnt, tirq_cnt;

    initial begin
        do_reset();

        // R1: reset state
        check(pin_out == 8'h00, "R1 pins", pin_out, 0);
        check(ch_irq == 8'h00 && tmr_irq == 2'b00, "R1 irqs", {ch_irq, tmr_irq}, 0);
        rd_addr = 4'd8; #1;
        check(rd_data == 16'h0, "R1 counter0", rd_data, 0);
        rd_addr = 4'd5; #1;
        check(rd_data == 16'h0, "R1 register5", rd_data, 0);

        // R10: register write and read back
        wr(6, 16'hBEEF);
        rd_addr = 4'd6; #1;
        check(rd_data == 16'hBEEF, "R10 readback", rd_data, 16'hBEEF);

        // R2: counting and holding
        wr(A_TMR, 5);
        for (int k = 0; k < 3; k++) step();
        rd_addr = 4'd8; #1;
        check(rd_data == 16'd8, "R2 count", rd_data, 8);
        repeat (4) @(negedge clk);
        check(rd_data == 16'd8, "R2 hold", rd_data, 8);

        // R2: overflow reload and pulse on counter 1
        wr(A_TMR + 1, 16'hFFFE);
        wr(A_REL + 1, 16'h0100);
        step();
        check(tmr_irq == 2'b00, "R2 no early pulse", tmr_irq, 0);
        step();
        rd_addr = 4'd9; #1;
        check(rd_data == 16'h0100, "R2 reload", rd_data, 16'h0100);
        check(tmr_irq == 2'b10, "R2 pulse", tmr_irq, 2);
        @(negedge clk);
        check(tmr_irq == 2'b00, "R2 pulse one cycle", tmr_irq, 0);

        // main compare table: R4 R5 R6 R7 R8 R11
        foreach (VECS[v]) begin
            do_reset();
            wr(A_TMR + VECS[v].tsel, 16'hFFFA);
            wr(A_REL + VECS[v].tsel, 16'hFFFC);
            wr(VECS[v].ch, 16'hFFFB);
            wr(A_CTL + VECS[v].ch, {VECS[v].tsel, VECS[v].mode});
            irq_cnt = 0;
            tirq_cnt = 0;
            for (int s = 1; s <= int'(VECS[v].steps); s++) begin
                step();
                irq_cnt += int'(ch_irq[VECS[v].ch]);
                tirq_cnt += int'(tmr_irq[0]) + int'(tmr_irq[1]);
                if (s == int'(VECS[v].wstep)) wr(VECS[v].ch, 16'hFFFD);
            end
            check(irq_cnt == int'(VECS[v].exp_irq), $sformatf("R4-6/R7/R8/R11 vec%0d irq", v),
                  irq_cnt, VECS[v].exp_irq);
            check(pin_out[VECS[v].ch] == VECS[v].exp_pin, $sformatf("R5/R7 vec%0d pin", v),
                  pin_out[VECS[v].ch], VECS[v].exp_pin);
            check(tirq_cnt == int'(VECS[v].exp_tirq), $sformatf("R2/R8 vec%0d ovf", v),
                  tirq_cnt, VECS[v].exp_tirq);
        end

        // R3: rising capture, latency and value
        do_reset();
        wr(A_TMR, 16'h1234);
        wr(A_CTL + 3, 3'b001);
        pin_in[3] = 1'b1;
        @(negedge clk);
        check(ch_irq[3] == 1'b0, "R3 latency 1", ch_irq[3], 0);
        @(negedge clk);
        check(ch_irq[3] == 1'b0, "R3 latency 2", ch_irq[3], 0);
        @(negedge clk);
        check(ch_irq[3] == 1'b1, "R3 capture irq", ch_irq[3], 1);
        rd_addr = 4'd3; #1;
        check(rd_data == 16'h1234, "R3 captured value", rd_data, 16'h1234);
        @(negedge clk);
        check(ch_irq[3] == 1'b0, "R3 pulse one cycle", ch_irq[3], 0);

        // R3: unselected falling edge ignored
        wr(A_TMR, 16'h2222);
        pin_in[3] = 1'b0;
        irq_cnt = 0;
        for (int k = 0; k < 5; k++) begin @(negedge clk); irq_cnt += int'(ch_irq[3]); end
        check(irq_cnt == 0, "R3 fall ignored irq", irq_cnt, 0);
        check(rd_data == 16'h1234, "R3 fall ignored value", rd_data, 16'h1234);

        // R3 R8: both edges on counter 1
        wr(A_TMR + 1, 16'h0777);
        wr(A_CTL + 4, 4'b1011);
        irq_cnt = 0;
        pin_in[4] = 1'b1;
        for (int k = 0; k < 5; k++) begin @(negedge clk); irq_cnt += int'(ch_irq[4]); end
        pin_in[4] = 1'b0;
        for (int k = 0; k < 5; k++) begin @(negedge clk); irq_cnt += int'(ch_irq[4]); end
        check(irq_cnt == 2, "R3 both edges", irq_cnt, 2);
        rd_addr = 4'd4; #1;
        check(rd_data == 16'h0777, "R8 capture from counter 1", rd_data, 16'h0777);

        // R11: disabled channel ignores edges
        pin_in[0] = 1'b1;
        irq_cnt = 0;
        for (int k = 0; k < 5; k++) begin @(negedge clk); irq_cnt += int'(ch_irq[0]); end
        rd_addr = 4'd0; #1;
        check(irq_cnt == 0 && rd_data == 16'h0, "R11 off capture", irq_cnt + rd_data, 0);

        // R9: paired mode
        do_reset();
        wr(A_GLB, 1);
        wr(1, 2);  wr(A_CTL + 1, 3'b101);
        wr(5, 4);  wr(A_CTL + 5, 3'b101);
        wr(2, 6);  wr(A_CTL + 2, 3'b100);
        wr(6, 6);  wr(A_CTL + 6, 3'b100);
        step();
        step();
        check(pin_out == 8'h02, "R9 pair low match", pin_out, 2);
        check(ch_irq[1] == 1'b1, "R9 irq ch1", ch_irq[1], 1);
        step();
        step();
        check(pin_out == 8'h00, "R9 pair high match", pin_out, 0);
        check(ch_irq[5] == 1'b1, "R9 irq ch5", ch_irq[5], 1);
        step();
        step();
        check(pin_out == 8'h04, "R9 simultaneous single toggle", pin_out, 4);
        check(ch_irq[2] && ch_irq[6], "R9 both irqs", {ch_irq[6], ch_irq[2]}, 3);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule